// File: doc/BRIEF.md
# APB Dual Down-Counter Timer

This block is an APB slave with two independent 32-bit down-counters in one 4 KB register window. Each counter has a load register, a background load register, a live count, a control register and a sticky interrupt flag. The control register selects one of three end-of-count behaviours: one-shot, periodic reload or free-running wrap. It also sets the counter width to 16 or 32 bits, picks a clock prescaler of 1, 16 or 256, and holds an interrupt enable and a run enable.

Each counter drives its own interrupt output. A third output is the OR of the two. For board-level testing, an integration mode replaces the two per-counter interrupts with bits from a test register. A fixed block of identification bytes sits at the top of the window. Every access completes in one APB access phase. Byte and halfword accesses are treated as full words, and read data is zero-padded.

Top module: `apb_dual_timer`

## Requirements
- R1: After reset, each counter's control reads 0x20 (interrupt enable set, all else clear), load reads 0, count reads 0xFFFFFFFF and raw status reads 0. All three interrupt outputs are low, and the integration control and test output registers are clear.
- R2: Counter 1 registers start at 0x00 and counter 2 registers at 0x20. Within each block the word offsets are: load +0x0, count +0x4, control +0x8, interrupt clear +0xC, raw status +0x10, masked status +0x14, background load +0x18. A load write sets both the load and the count. A background load write sets the load only. Both offsets read back the load.
- R3: The control bits are: bit0 one-shot, bit1 32-bit width, bits3:2 prescale, bit5 interrupt enable, bit6 periodic, bit7 enable. Only these bits are stored. Bit 4 and bits 31:8 read 0.
- R4: While enabled, each prescaled tick lowers the count by one. A tick that moves the count from 1 to 0 sets the raw status bit on that same edge. With prescale 0, a tick occurs on every clock edge after the edge that wrote the enable.
- R5: Prescale code 1 gives one tick per 16 clocks. Codes 2 and 3 both give one tick per 256 clocks. Each control write restarts the prescaler.
- R6: On a tick with the count at 0, the next count depends on the mode. In one-shot mode (bit0=1) the count stays at 0. In periodic mode (bit0=0, bit6=1) it reloads from the load register. In free-running mode (bit0=0, bit6=0) it wraps to all ones.
- R7: In 16-bit mode (bit1=0), only the low 16 bits count, wrap and reload. The upper 16 bits keep their value, and a count read returns them joined with the live low half.
- R8: Raw status stays set until a write to the interrupt clear offset. Masked status, and the counter's interrupt output when the integration mode is off, equal raw status AND the interrupt enable bit.
- R9: When bit0 of the integration control register at 0xF00 is set, interrupts 1 and 2 follow bits 0 and 1 of the test output register at 0xF04. The combined output is always the OR of the two selected interrupts. 0xF00 reads back its bit0, and 0xF04 reads 0.
- R10: Words 0xFD0 to 0xFFC read, in address order, the bytes 0x04,0x00,0x00,0x00,0x23,0xB8,0x1B,0x00,0x0D,0xF0,0x05,0xB1 in bits 7:0.
- R11: Reads from undefined offsets return 0. Writes to them change no register.
- R12: PREADY is always high and PSLVERR is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tint1 | output | 1 | Counter 1 interrupt |
| tint2 | output | 1 | Counter 2 interrupt |
| tintc | output | 1 | OR of tint1 and tint2 |

## Verification
The bench builds the block with its default prescale exponents of 4 and 8, so the 16 and 256 clock divisors are run out in full. The exact interrupt edge can be pinned for every prescale code, including the code-3 alias, within a few hundred cycles. The one-shot, periodic and free-running end-of-count cases are each pinned to a single clock edge by reading the count right after zero is reached. The 16-bit wrap that keeps the upper half is checked the same way.

// File: rtl/apb_dual_timer.sv
module apb_dual_timer #(
  parameter int DIV_MID_LOG2 = 4,
  parameter int DIV_HI_LOG2  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  output logic        tint1,
  output logic        tint2,
  output logic        tintc
);
  localparam int PRE_W = DIV_HI_LOG2;
  localparam logic [PRE_W-1:0] MID_TOP = PRE_W'((1 << DIV_MID_LOG2) - 1);
  localparam logic [PRE_W-1:0] HI_TOP  = PRE_W'((1 << DIV_HI_LOG2) - 1);
  localparam logic [7:0] CTRL_MASK = 8'hEF;

  logic        wr;
  logic        in_tmr;
  logic [9:0]  word;
  logic        itm_q;
  logic [1:0]  itop_q;
  logic [7:0]  ctrl_q [2];
  logic [31:0] cnt_q  [2];
  logic        ris_q  [2];
  logic [31:0] rd_t   [2];
  logic [1:0]  mis;

  assign wr      = psel & penable & pwrite;
  assign word    = paddr[11:2];
  assign in_tmr  = (paddr[11:6] == 6'd0);
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    logic             hit;
    logic [31:0]      load_q;
    logic [PRE_W-1:0] pre_q;
    logic             wide, en, term, tick;
    logic [31:0]      cur, nxt;

    assign hit  = wr && in_tmr && (paddr[5] == 1'(g));
    assign wide = ctrl_q[g][1];
    assign en   = ctrl_q[g][7];
    assign cur  = wide ? cnt_q[g] : {16'h0, cnt_q[g][15:0]};
    assign mis[g] = ris_q[g] & ctrl_q[g][5];

    always_comb begin
      case (ctrl_q[g][3:2])
        2'd0:    term = 1'b1;
        2'd1:    term = (pre_q == MID_TOP);
        default: term = (pre_q == HI_TOP);
      endcase
    end
    assign tick = en & term;

    always_comb begin
      if (cur != 32'd0)
        nxt = wide ? cnt_q[g] - 32'd1 : {cnt_q[g][31:16], cnt_q[g][15:0] - 16'd1};
      else if (ctrl_q[g][0])
        nxt = cnt_q[g];
      else if (ctrl_q[g][6])
        nxt = wide ? load_q : {cnt_q[g][31:16], load_q[15:0]};
      else
        nxt = wide ? 32'hFFFF_FFFF : {cnt_q[g][31:16], 16'hFFFF};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[g] <= 8'h20;
        load_q    <= 32'd0;
        cnt_q[g]  <= 32'hFFFF_FFFF;
        ris_q[g]  <= 1'b0;
        pre_q     <= '0;
      end else begin
        if (hit && paddr[4:2] == 3'd2) pre_q <= '0;
        else if (!en || tick)          pre_q <= '0;
        else                           pre_q <= pre_q + 1'b1;

        if (hit && paddr[4:2] == 3'd2) ctrl_q[g] <= pwdata[7:0] & CTRL_MASK;

        if (hit && (paddr[4:2] == 3'd0 || paddr[4:2] == 3'd6)) load_q <= pwdata;

        if (hit && paddr[4:2] == 3'd0) cnt_q[g] <= pwdata;
        else if (tick)                 cnt_q[g] <= nxt;

        if (tick && cur == 32'd1 && !(hit && paddr[4:2] == 3'd0)) ris_q[g] <= 1'b1;
        else if (hit && paddr[4:2] == 3'd3)                        ris_q[g] <= 1'b0;
      end
    end

    always_comb begin
      case (paddr[4:2])
        3'd0, 3'd6: rd_t[g] = load_q;
        3'd1:       rd_t[g] = cnt_q[g];
        3'd2:       rd_t[g] = {24'h0, ctrl_q[g]};
        3'd4:       rd_t[g] = {31'h0, ris_q[g]};
        3'd5:       rd_t[g] = {31'h0, mis[g]};
        default:    rd_t[g] = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      itm_q  <= 1'b0;
      itop_q <= 2'b00;
    end else if (wr) begin
      if (paddr == 12'hF00) itm_q  <= pwdata[0];
      if (paddr == 12'hF04) itop_q <= pwdata[1:0];
    end
  end

  always_comb begin
    prdata = 32'h0;
    if (in_tmr)
      prdata = rd_t[paddr[5]];
    else if (word == 10'h3C0)
      prdata = {31'h0, itm_q};
    else if (word >= 10'h3F4) begin
      case (word[3:0])
        4'h4:    prdata = 32'h04;
        4'h8:    prdata = 32'h23;
        4'h9:    prdata = 32'hB8;
        4'hA:    prdata = 32'h1B;
        4'hC:    prdata = 32'h0D;
        4'hD:    prdata = 32'hF0;
        4'hE:    prdata = 32'h05;
        4'hF:    prdata = 32'hB1;
        default: prdata = 32'h00;
      endcase
    end
  end

  assign tint1 = itm_q ? itop_q[0] : mis[0];
  assign tint2 = itm_q ? itop_q[1] : mis[1];
  assign tintc = tint1 | tint2;
endmodule

// File: rtl/apb_dual_timer_chk.sv
module apb_dual_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [31:0] pwdata,
  input logic        tint1,
  input logic        tint2,
  input logic        itm_en,
  input logic [7:0]  ctrl0,
  input logic [31:0] cnt0,
  input logic        ris0
);
  logic wr;
  assign wr = psel && penable && pwrite;

  assert_load_sets_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 12'h000) |=> cnt0 == $past(pwdata));

  assert_oneshot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl0[0] && cnt0 == 32'd0 && !(wr && paddr[11:5] == 7'd0)) |=> cnt0 == 32'd0);

  assert_raw_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ris0 && !(wr && paddr == 12'h00C)) |=> ris0);

  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 12'h00C && !ctrl0[7]) |=> !ris0);

  assert_test_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 12'hF04 && itm_en) |=> (tint1 == $past(pwdata[0]) && tint2 == $past(pwdata[1])));
endmodule

bind apb_dual_timer apb_dual_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .tint1(tint1), .tint2(tint2),
  .itm_en(itm_q), .ctrl0(ctrl_q[0]), .cnt0(cnt_q[0]), .ris0(ris_q[0])
);

// File: tb/apb_dual_timer_test.sv
module apb_dual_timer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = 0;
  logic [31:0] pwdata = 0;
  logic [31:0] prdata;
  logic        pready, pslverr, tint1, tint2, tintc;
  int checks = 0, failures = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  apb_dual_timer uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk) penable = 1;
    #1 d = prdata;
    chk("R12 pready", {31'h0, pready}, 32'h1);
    chk("R12 pslverr", {31'h0, pslverr}, 32'h0);
    @(negedge clk) begin psel = 0; penable = 0; end
  endtask

  task automatic quiesce();
    wr(12'h008, 32'h20); wr(12'h00C, 0);
    wr(12'h028, 32'h20); wr(12'h02C, 0);
  endtask

  task automatic t_reset();
    chk("R1 tint1", {31'h0, tint1}, 0);
    chk("R1 tintc", {31'h0, tintc}, 0);
    rd(12'h008, rv); chk("R1 ctrl", rv, 32'h20);
    rd(12'h020, rv); chk("R1 load2", rv, 0);
    rd(12'h024, rv); chk("R1 count2", rv, 32'hFFFF_FFFF);
    rd(12'h010, rv); chk("R1 ris", rv, 0);
    rd(12'hF00, rv); chk("R1 itcr", rv, 0);
  endtask

  task automatic t_regs();
    wr(12'h000, 32'h1111_2222);
    rd(12'h004, rv); chk("R2 load sets count", rv, 32'h1111_2222);
    wr(12'h018, 32'h3333_4444);
    rd(12'h004, rv); chk("R2 bgload keeps count", rv, 32'h1111_2222);
    rd(12'h000, rv); chk("R2 load readback", rv, 32'h3333_4444);
    rd(12'h018, rv); chk("R2 bgload readback", rv, 32'h3333_4444);
    wr(12'h020, 32'h55);
    rd(12'h000, rv); chk("R2 timer1 untouched by timer2", rv, 32'h3333_4444);
    rd(12'h024, rv); chk("R2 timer2 count", rv, 32'h55);
    wr(12'h028, 32'hFFFF_FF7F);
    rd(12'h028, rv); chk("R3 control mask", rv, 32'h6F);
    wr(12'h028, 32'h20);
  endtask

  task automatic t_count();
    wr(12'h000, 100);
    wr(12'h008, 32'h82);
    rd(12'h004, rv); chk("R4 first tick", rv, 99);
    rd(12'h004, rv); chk("R4 one per clock", rv, 97);
    quiesce();
    wr(12'h000, 5);
    wr(12'h008, 32'hA3);
    repeat (4) @(negedge clk);
    chk("R4 no irq before zero", {31'h0, tint1}, 0);
    @(negedge clk);
    chk("R4 irq at zero", {31'h0, tint1}, 1);
    chk("R9 combined", {31'h0, tintc}, 1);
    quiesce();
  endtask

  task automatic t_prescale(logic [1:0] code, int div);
    wr(12'h020, 1);
    wr(12'h028, 32'hA3 | (32'(code) << 2));
    repeat (div - 1) @(negedge clk);
    chk("R5 before divided tick", {31'h0, tint2}, 0);
    @(negedge clk);
    chk("R5 divided tick", {31'h0, tint2}, 1);
    quiesce();
  endtask

  task automatic t_modes();
    wr(12'h000, 2); wr(12'h008, 32'hC2);
    repeat (2) @(negedge clk);
    rd(12'h004, rv); chk("R6 periodic reload", rv, 2);
    quiesce();
    wr(12'h000, 1); wr(12'h008, 32'h82);
    @(negedge clk);
    rd(12'h004, rv); chk("R6 free wrap 32", rv, 32'hFFFF_FFFF);
    quiesce();
    wr(12'h000, 1); wr(12'h008, 32'h83);
    repeat (3) @(negedge clk);
    rd(12'h004, rv); chk("R6 oneshot hold", rv, 0);
    quiesce();
    wr(12'h000, 32'h1234_0001); wr(12'h008, 32'h80);
    @(negedge clk);
    rd(12'h004, rv); chk("R7 16-bit wrap keeps top", rv, 32'h1234_FFFF);
    quiesce();
    wr(12'h000, 32'hABCD_0002); wr(12'h008, 32'hC0);
    repeat (2) @(negedge clk);
    rd(12'h004, rv); chk("R7 16-bit reload", rv, 32'hABCD_0002);
    quiesce();
  endtask

  task automatic t_status();
    wr(12'h000, 1); wr(12'h008, 32'h83);
    repeat (2) @(negedge clk);
    wr(12'h008, 32'h83);
    chk("R8 masked off", {31'h0, tint1}, 0);
    rd(12'h010, rv); chk("R8 raw set", rv, 1);
    rd(12'h014, rv); chk("R8 masked status", rv, 0);
    wr(12'h008, 32'hA3);
    chk("R8 masked on", {31'h0, tint1}, 1);
    wr(12'h00C, 0);
    rd(12'h010, rv); chk("R8 cleared", rv, 0);
    chk("R8 irq cleared", {31'h0, tint1}, 0);
    quiesce();
  endtask

  task automatic t_itm();
    wr(12'h000, 1); wr(12'h008, 32'hA3);
    repeat (2) @(negedge clk);
    chk("R9 normal path", {31'h0, tint1}, 1);
    wr(12'hF00, 1); wr(12'hF04, 2);
    chk("R9 override t1", {31'h0, tint1}, 0);
    chk("R9 override t2", {31'h0, tint2}, 1);
    chk("R9 combined", {31'h0, tintc}, 1);
    wr(12'hF04, 0);
    chk("R9 combined low", {31'h0, tintc}, 0);
    rd(12'hF00, rv); chk("R9 itcr readback", rv, 1);
    rd(12'hF04, rv); chk("R9 itop reads zero", rv, 0);
    wr(12'hF00, 0);
    chk("R9 back to normal", {31'h0, tint1}, 1);
    quiesce();
  endtask

  task automatic t_id();
    logic [7:0] idv [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                             8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 12; i++) begin
      rd(12'hFD0 + 12'(4 * i), rv);
      chk("R10 id byte", rv, {24'h0, idv[i]});
    end
  endtask

  task automatic t_undef();
    wr(12'h000, 32'hAAAA_5555);
    wr(12'h040, 1); wr(12'h058, 7); wr(12'h01C, 3); wr(12'hF08, 1);
    rd(12'h000, rv); chk("R11 load unchanged", rv, 32'hAAAA_5555);
    rd(12'h004, rv); chk("R11 count unchanged", rv, 32'hAAAA_5555);
    rd(12'h01C, rv); chk("R11 hole reads zero", rv, 0);
    rd(12'h040, rv); chk("R11 beyond timers", rv, 0);
    rd(12'hFCC, rv); chk("R11 below id", rv, 0);
    chk("R11 outputs quiet", {29'h0, tint1, tint2, tintc}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_count();
    t_prescale(2'd1, 16);
    t_prescale(2'd2, 256);
    t_prescale(2'd3, 256);
    t_modes();
    t_status();
    t_itm();
    t_id();
    t_undef();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule